// File: doc/BRIEF.md
# Dual-Channel UART Standby Power Controller

This block decides whether the internal clock domains of a two-channel UART run or are held stopped. Software puts the device to sleep and wakes it with command codes written to the command register of the first channel (channel A). While the device sleeps, the only clock that runs is the free-running oscillator clock, which also clocks this controller. A small always-on island keeps working in every state. It samples the parallel input pins and holds the parallel output register, so that both remain usable while the rest of the chip is stopped.

A resume command does not turn the clocks back on at once. A counter on the oscillator clock first covers a start-up window of about 25 microseconds. The clock enables return when the count expires. The controller keeps a flag that marks register contents as untrustworthy. The flag is set when the device goes to sleep and stays set after the device wakes, until software writes an acknowledge code. The interrupt from the gated domains is held low whenever they are not running. A hardware reset always returns the block to full operation.

Top module: `duart_pwr_ctrl`

## Requirements
- R1: After reset, `ready` is 1, every bit of `clk_en` is 1, `regs_invalid` is 0 and `out_port` is 0.
- R2: While active, a write with `cmd_chan`=0 (channel A) and `cmd_code`=4'hC (sleep) takes effect at the clock edge that samples it: `ready` and all `clk_en` bits are 0 after that edge. Other channel A codes, apart from 4'hE, leave the state unchanged.
- R3: A write with `cmd_chan`=1 (channel B) never changes `ready`, `clk_en` or `regs_invalid`, whatever its code and whatever the state.
- R4: While not active (asleep or waking), every channel A code except 4'hD (resume) is ignored. A sleep code issued during the wake window does not lengthen the window and does not cut it short.
- R5: After a channel A write of 4'hD is sampled while asleep, `ready` and all `clk_en` bits return to 1 exactly WAKE_CYC oscillator edges later, and no earlier. The default is 92 cycles, which is about 25 us at 3.6864 MHz.
- R6: `regs_invalid` becomes 1 at the same edge that enters sleep. It stays 1 through the wake-up. It clears only when a channel A write of 4'hE (acknowledge) arrives while active.
- R7: In every state, `in_val` follows `in_pins` two edges later, and a pulse on `out_wr` loads `out_data` into `out_port` at the next edge.
- R8: `irq_out` equals `irq_in` while `ready` is 1 and is 0 otherwise.
- R9: Asserting `rst_n` during sleep or during the wake window returns the block to the R1 state without waiting for a clock edge.
- R10: All bits of `clk_en` always equal `ready`, and they change only on the oscillator clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_chan | input | 1 | Channel of the write: 0 = A, 1 = B |
| cmd_code | input | 4 | Command code written |
| irq_in | input | 1 | Interrupt request from the gated domains |
| in_pins | input | IO_W | Parallel input port pins |
| out_wr | input | 1 | Output port write strobe |
| out_data | input | IO_W | Output port write data |
| clk_en | output | N_DOM | Per-domain clock enables |
| ready | output | 1 | Clocks are running and the device is operational |
| regs_invalid | output | 1 | Registers must be reprogrammed |
| irq_out | output | 1 | Masked interrupt request |
| in_val | output | IO_W | Synchronized input port value |
| out_port | output | IO_W | Output port register |

## Verification
The hardest situation to reach from the ports is a stray sleep command that lands in the middle of the wake window. The bench issues a resume and counts oscillator edges. On the tenth edge it drives a channel A sleep write, then checks that `ready` still rises on exactly the WAKE_CYC-th edge. The bench also applies reset during sleep and during the wake window to confirm that both paths recover. It sweeps all sixteen codes on both channels, both while active and while asleep, and it writes all 256 output values while asleep.

// File: rtl/duart_pwr_pkg.sv
package duart_pwr_pkg;
  typedef enum logic [1:0] {
    PS_ACTIVE  = 2'd0,
    PS_STANDBY = 2'd1,
    PS_WAKE    = 2'd2
  } pwr_state_e;

  typedef struct packed {
    logic go_standby;
    logic go_active;
    logic ack_flag;
  } cmd_req_t;
endpackage

// File: rtl/duart_pwr_cmd_dec.sv
module duart_pwr_cmd_dec
  import duart_pwr_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter logic [CODE_W-1:0] STBY_CODE = 4'hC,
  parameter logic [CODE_W-1:0] ACT_CODE  = 4'hD,
  parameter logic [CODE_W-1:0] ACK_CODE  = 4'hE
) (
  input  logic              cmd_wr,
  input  logic              cmd_chan,
  input  logic [CODE_W-1:0] cmd_code,
  output cmd_req_t          req
);
  logic chan_a_wr;

  always_comb begin
    chan_a_wr      = cmd_wr && !cmd_chan;
    req.go_standby = chan_a_wr && (cmd_code == STBY_CODE);
    req.go_active  = chan_a_wr && (cmd_code == ACT_CODE);
    req.ack_flag   = chan_a_wr && (cmd_code == ACK_CODE);
  end
endmodule

// File: rtl/duart_pwr_wake_timer.sv
module duart_pwr_wake_timer #(
  parameter int WAKE_CYC = 92
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic done
);
  localparam int CNT_W = $clog2(WAKE_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAKE_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    done  = run && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (start)
      cnt_d = '0;
    else if (run && !done)
      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/duart_pwr_io_island.sv
module duart_pwr_io_island #(
  parameter int IO_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IO_W-1:0] in_pins,
  output logic [IO_W-1:0] in_val,
  input  logic            out_wr,
  input  logic [IO_W-1:0] out_data,
  output logic [IO_W-1:0] out_port
);
  logic [IO_W-1:0] sync_q [SYNC_STAGES];
  logic [IO_W-1:0] out_d;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sync_q[s] <= '0;
      else if (s == 0) sync_q[s] <= in_pins;
      else             sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end

  assign in_val = sync_q[SYNC_STAGES-1];

  always_comb out_d = out_wr ? out_data : out_port;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_port <= '0;
    else        out_port <= out_d;
  end
endmodule

// File: rtl/duart_pwr_ctrl.sv
module duart_pwr_ctrl
  import duart_pwr_pkg::*;
#(
  parameter int N_DOM    = 3,
  parameter int IO_W     = 8,
  parameter int WAKE_CYC = 92,
  parameter logic [3:0] STBY_CODE = 4'hC,
  parameter logic [3:0] ACT_CODE  = 4'hD,
  parameter logic [3:0] ACK_CODE  = 4'hE
) (
  input  logic             clk_osc,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic             cmd_chan,
  input  logic [3:0]       cmd_code,
  input  logic             irq_in,
  input  logic [IO_W-1:0]  in_pins,
  input  logic             out_wr,
  input  logic [IO_W-1:0]  out_data,
  output logic [N_DOM-1:0] clk_en,
  output logic             ready,
  output logic             regs_invalid,
  output logic             irq_out,
  output logic [IO_W-1:0]  in_val,
  output logic [IO_W-1:0]  out_port
);
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  cmd_req_t   req;
  pwr_state_e state_q, state_d;
  logic       wake_done;
  logic       flag_q, flag_d;
  logic       en_d;

  duart_pwr_cmd_dec #(
    .CODE_W(4), .STBY_CODE(STBY_CODE), .ACT_CODE(ACT_CODE), .ACK_CODE(ACK_CODE)
  ) u_dec (
    .cmd_wr(cmd_wr), .cmd_chan(cmd_chan), .cmd_code(cmd_code), .req(req)
  );

  duart_pwr_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_timer (
    .clk(clk_osc), .rst_n(rst_s_n),
    .start((state_q == PS_STANDBY) && req.go_active),
    .run(state_q == PS_WAKE),
    .done(wake_done)
  );

  always_comb begin
    state_d = state_q;
    flag_d  = flag_q;
    unique case (state_q)
      PS_ACTIVE: begin
        if (req.go_standby) begin
          state_d = PS_STANDBY;
          flag_d  = 1'b1;
        end else if (req.ack_flag) begin
          flag_d  = 1'b0;
        end
      end
      PS_STANDBY: if (req.go_active) state_d = PS_WAKE;
      PS_WAKE:    if (wake_done)     state_d = PS_ACTIVE;
      default:    state_d = PS_ACTIVE;
    endcase
    en_d = (state_d == PS_ACTIVE);
  end

  always_ff @(posedge clk_osc or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= PS_ACTIVE;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      flag_q  <= flag_d;
    end
  end

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom_en
    always_ff @(posedge clk_osc or negedge rst_s_n) begin
      if (!rst_s_n) clk_en[d] <= 1'b1;
      else          clk_en[d] <= en_d;
    end
  end

  assign ready        = (state_q == PS_ACTIVE);
  assign regs_invalid = flag_q;
  assign irq_out      = irq_in && ready;

  duart_pwr_io_island #(.IO_W(IO_W), .SYNC_STAGES(2)) u_io (
    .clk(clk_osc), .rst_n(rst_s_n),
    .in_pins(in_pins), .in_val(in_val),
    .out_wr(out_wr), .out_data(out_data), .out_port(out_port)
  );
endmodule

// File: rtl/duart_pwr_ctrl_chk.sv
module duart_pwr_ctrl_chk #(
  parameter int N_DOM    = 3,
  parameter int IO_W     = 8,
  parameter int WAKE_CYC = 92,
  parameter logic [3:0] STBY_CODE = 4'hC,
  parameter logic [3:0] ACT_CODE  = 4'hD,
  parameter logic [3:0] ACK_CODE  = 4'hE
) (
  input logic             clk_osc,
  input logic             rst_n,
  input logic             cmd_wr,
  input logic             cmd_chan,
  input logic [3:0]       cmd_code,
  input logic             irq_in,
  input logic [IO_W-1:0]  in_pins,
  input logic             out_wr,
  input logic [IO_W-1:0]  out_data,
  input logic [N_DOM-1:0] clk_en,
  input logic             ready,
  input logic             regs_invalid,
  input logic             irq_out,
  input logic [IO_W-1:0]  in_val,
  input logic [IO_W-1:0]  out_port
);
  localparam int CW = $clog2(WAKE_CYC + 2);
  logic [1:0]    age_q;
  logic          settled;
  logic          pend_q;
  logic [CW-1:0] wcnt_q;

  assign settled = age_q[1];

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) begin
      age_q  <= 2'b00;
      pend_q <= 1'b0;
      wcnt_q <= '0;
    end else begin
      age_q <= {age_q[0], 1'b1};
      if (ready) begin
        pend_q <= 1'b0;
      end else if (!pend_q && cmd_wr && !cmd_chan && cmd_code == ACT_CODE) begin
        pend_q <= 1'b1;
        wcnt_q <= '0;
      end else if (pend_q) begin
        wcnt_q <= wcnt_q + 1'b1;
      end
    end
  end

  AST_STBY_ENTER: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (settled && ready && cmd_wr && !cmd_chan && cmd_code == STBY_CODE) |=> (!ready && clk_en == '0)); // R2
  AST_CHB_NO_EFFECT: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (settled && cmd_wr && cmd_chan) |=> ($stable(ready) && $stable(regs_invalid))); // R3
  AST_WAKE_EXACT: assert property (@(posedge clk_osc) disable iff (!rst_n)
    $rose(ready) |-> (wcnt_q == CW'(WAKE_CYC))); // R5
  AST_FLAG_ON_SLEEP: assert property (@(posedge clk_osc) disable iff (!rst_n)
    $fell(ready) |-> regs_invalid); // R6
  AST_OUT_LOAD: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (settled && out_wr) |=> (out_port == $past(out_data))); // R7
  AST_IRQ_MASK: assert property (@(posedge clk_osc) disable iff (!rst_n)
    !ready |-> !irq_out); // R8
  AST_EN_MATCH: assert property (@(posedge clk_osc) disable iff (!rst_n)
    clk_en == {N_DOM{ready}}); // R10
endmodule

bind duart_pwr_ctrl duart_pwr_ctrl_chk #(
  .N_DOM(N_DOM), .IO_W(IO_W), .WAKE_CYC(WAKE_CYC),
  .STBY_CODE(STBY_CODE), .ACT_CODE(ACT_CODE), .ACK_CODE(ACK_CODE)
) u_chk (.*);

// File: tb/duart_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module duart_pwr_ctrl_bench;
  localparam int N_DOM = 3;
  localparam int IO_W  = 8;
  localparam int W     = 92;
  localparam logic [3:0] C_STBY = 4'hC, C_ACT = 4'hD, C_ACK = 4'hE;

  logic clk_osc = 1'b0;
  logic rst_n, cmd_wr, cmd_chan, irq_in, out_wr;
  logic [3:0] cmd_code;
  logic [IO_W-1:0] in_pins, out_data, in_val, out_port;
  logic [N_DOM-1:0] clk_en;
  logic ready, regs_invalid, irq_out;
  int checks = 0, fails = 0;

  always #2 clk_osc = ~clk_osc;

  duart_pwr_ctrl u_duart_pwr_ctrl (
    .clk_osc(clk_osc), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_chan(cmd_chan),
    .cmd_code(cmd_code), .irq_in(irq_in), .in_pins(in_pins), .out_wr(out_wr),
    .out_data(out_data), .clk_en(clk_en), .ready(ready),
    .regs_invalid(regs_invalid), .irq_out(irq_out), .in_val(in_val),
    .out_port(out_port)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic ch, input logic [3:0] code);
    @(negedge clk_osc);
    cmd_wr = 1'b1; cmd_chan = ch; cmd_code = code;
    @(negedge clk_osc);
    cmd_wr = 1'b0;
  endtask

  task automatic chk_state(input string req, input bit exp_rdy, input bit exp_flag);
    chk(ready == exp_rdy, req, int'(ready), int'(exp_rdy));
    chk(clk_en == {N_DOM{exp_rdy}}, req, int'(clk_en), exp_rdy ? 7 : 0);
    chk(regs_invalid == exp_flag, req, int'(regs_invalid), int'(exp_flag));
  endtask

  task automatic do_reset();
    @(negedge clk_osc);
    rst_n = 1'b0;
    #1;
    chk_state("R9 async reset", 1'b1, 1'b0);
    @(negedge clk_osc);
    rst_n = 1'b1;
    repeat (3) @(negedge clk_osc);
  endtask

  task automatic wake_measure(input int inject_at, input string req);
    int n;
    do_cmd(1'b0, C_ACT);
    n = 0;
    while (!ready && n < W + 20) begin
      if (n == 1) chk(irq_out == 1'b0, "R8 irq masked in wake", int'(irq_out), 0);
      cmd_wr = (n == inject_at); cmd_chan = 1'b0; cmd_code = C_STBY;
      @(negedge clk_osc);
      cmd_wr = 1'b0;
      n++;
    end
    chk(n == W, req, n, W);
    chk(clk_en == '1, req, int'(clk_en), 7);
  endtask

  initial begin
    #(4 * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_wr = 1'b0; cmd_chan = 1'b0; cmd_code = '0;
    irq_in = 1'b1; in_pins = '0; out_wr = 1'b0; out_data = '0;
    repeat (3) @(negedge clk_osc);
    rst_n = 1'b1;
    repeat (3) @(negedge clk_osc);

    chk_state("R1 reset state", 1'b1, 1'b0);
    chk(out_port == '0, "R1 out_port", int'(out_port), 0);
    chk(irq_out == 1'b1, "R8 irq pass active", int'(irq_out), 1);

    for (int c = 0; c < 16; c++) begin
      do_cmd(1'b1, 4'(c));
      chk_state("R3 chan B active", 1'b1, 1'b0);
    end
    for (int c = 0; c < 16; c++) begin
      if (4'(c) == C_STBY) continue;
      do_cmd(1'b0, 4'(c));
      chk_state("R2 other A codes active", 1'b1, 1'b0);
    end

    do_cmd(1'b0, C_STBY);
    chk_state("R2 R6 enter sleep", 1'b0, 1'b1);
    chk(irq_out == 1'b0, "R8 irq masked asleep", int'(irq_out), 1'b0);

    for (int c = 0; c < 16; c++) begin
      do_cmd(1'b1, 4'(c));
      chk_state("R3 chan B asleep", 1'b0, 1'b1);
      if (4'(c) != C_ACT) begin
        do_cmd(1'b0, 4'(c));
        chk_state("R4 A code ignored asleep", 1'b0, 1'b1);
      end
    end

    for (int v = 0; v < 256; v++) begin
      @(negedge clk_osc);
      out_wr = 1'b1; out_data = 8'(v);
      @(negedge clk_osc);
      out_wr = 1'b0;
      chk(out_port == 8'(v), "R7 out write asleep", int'(out_port), v);
    end
    for (int v = 0; v < 16; v++) begin
      logic [7:0] prev, pat;
      prev = in_val;
      pat  = 8'(v * 37 + 5);
      @(negedge clk_osc);
      in_pins = pat;
      @(negedge clk_osc);
      chk(in_val == prev, "R7 in sync stage1", int'(in_val), int'(prev));
      @(negedge clk_osc);
      chk(in_val == pat, "R7 in sync stage2", int'(in_val), int'(pat));
    end

    wake_measure(-1, "R5 wake delay");
    chk(regs_invalid == 1'b1, "R6 flag after wake", int'(regs_invalid), 1);
    chk(irq_out == 1'b1, "R8 irq after wake", int'(irq_out), 1);
    do_cmd(1'b1, C_ACK);
    chk(regs_invalid == 1'b1, "R6 chan B ack ignored", int'(regs_invalid), 1);
    do_cmd(1'b0, C_ACK);
    chk(regs_invalid == 1'b0, "R6 ack clears", int'(regs_invalid), 0);

    do_cmd(1'b0, C_STBY);
    chk_state("R2 sleep again", 1'b0, 1'b1);
    wake_measure(10, "R4 R5 sleep cmd during wake");

    do_cmd(1'b0, C_STBY);
    chk_state("R2 sleep before reset", 1'b0, 1'b1);
    do_reset();
    chk_state("R9 reset from sleep", 1'b1, 1'b0);

    do_cmd(1'b0, C_STBY);
    do_cmd(1'b0, C_ACT);
    repeat (5) @(negedge clk_osc);
    chk(ready == 1'b0, "R5 not early", int'(ready), 0);
    do_reset();
    chk_state("R9 reset from wake", 1'b1, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule